// File: doc/BRIEF.md
# Low-Power-Idle Status and Wake-Error Register Block

This block serves the energy-saving idle reporting for one Ethernet port. It keeps a 16-bit count of wake-up faults and builds a 16-bit control/status word. A host reads and writes both through a simple synchronous register bus. The PCS supplies three inputs: a wake-timer-done strobe, and two levels that say whether low-power idle is currently present on the transmit path and on the receive path. A fourth input carries the hardware enable for 100BASE-TX energy-efficient operation. A fiber-mode input turns the whole idle function off.

The fault counter advances once for each rising edge of the wake-timer-done strobe. It stops at all ones and clears when the host reads it. The status word places a sticky "idle has been seen" flag beside a live "idle is present now" flag for each direction. The host clears a sticky flag by writing a 1 to it. The word also holds a few reserved bits, some writable and some fixed. Bus reads are registered, so read data appears on the cycle after the read strobe.

Top module: `lpi_status_regs`

## Requirements
- R1: After reset the counter (byte address 0xE2) reads 0x0000. The status word (byte address 0xE4) reads 0x8060 when the EEE enable input and both idle inputs are low.
- R2: The counter gains exactly 1 for each low-to-high change of `wake_done`. Holding `wake_done` high adds nothing more.
- R3: The counter stops at 0xFFFF and does not wrap.
- R4: A read of 0xE2 returns the counter value on `bus_rdata` one cycle after the read strobe. The counter then holds 0.
- R5: If a `wake_done` rising edge arrives in the same cycle as a counter read, the read returns the old value and the counter becomes 1.
- R6: Status bit 13 sets while `tx_lpi` is high and stays set after `tx_lpi` falls. Writing 1 to bit 13 at 0xE4 clears it. Writing 0 to bit 13 leaves it unchanged.
- R7: Status bit 11 does the same for `rx_lpi`.
- R8: When an idle input is high in the same cycle as a write of 1 to its sticky bit, the sticky bit stays set.
- R9: Status bits 12 and 10 show the present levels of `tx_lpi` and `rx_lpi`, sampled in the read cycle.
- R10: Bit 15 (reset 1) and bits 9:8 (reset 00) can be read and written. Bit 14 shows `hw_eee_en`. Bits 6 and 5 always read 1. Bit 7 and bits 4:0 always read 0, and writes to them do nothing.
- R11: While `fiber_mode` is high, the counter, both sticky bits and both live bits are held at 0, and wake edges and idle inputs are ignored.
- R12: A read of any other address returns 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Byte address of the register access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data; it holds its value between reads |
| wake_done | input | 1 | Wake-timer-done indication from the PCS |
| tx_lpi | input | 1 | Transmit path is in low-power idle |
| rx_lpi | input | 1 | Receive path is in low-power idle |
| hw_eee_en | input | 1 | Hardware 100BASE-TX EEE enable |
| fiber_mode | input | 1 | Fiber operation; the idle function is disabled |

## Verification
Every state change lands on the first clock edge after the stimulus. Read data for a strobe in cycle N appears on `bus_rdata` after edge N+1. It reflects the counter and sticky state as they were before that edge, and the live inputs as they were in cycle N. The bench drives inputs on the falling edge, so its behavioural model updates on the rising edge from the same settled inputs. On every falling edge the bench compares `bus_rdata` with the model. Directed reads are then checked against hand-worked constants one falling edge after each strobe.

// File: rtl/lpi_reg_pkg.sv
package lpi_reg_pkg;

    localparam int REG_W = 16;

    // Status word bit positions
    localparam int POS_RSV_HI  = 15;
    localparam int POS_HW_EEE  = 14;
    localparam int POS_TX_SEEN = 13;
    localparam int POS_TX_LIVE = 12;
    localparam int POS_RX_SEEN = 11;
    localparam int POS_RX_LIVE = 10;
    localparam int POS_RSV_LO  = 8;
    localparam int POS_NP_ABLE = 6;
    localparam int POS_NP_LOC  = 5;

    typedef struct packed {
        logic       hi;
        logic [1:0] lo;
    } csr_rw_t;

    typedef struct packed {
        logic seen;
        logic live;
    } lpi_flag_t;

    localparam csr_rw_t CSR_RW_RST = '{hi: 1'b1, lo: 2'b00};

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CSR  = 2'd2
    } reg_sel_e;

    function automatic logic [REG_W-1:0] pack_csr(
        input csr_rw_t   rw,
        input logic      hw_en,
        input lpi_flag_t tx,
        input lpi_flag_t rx
    );
        logic [REG_W-1:0] w;
        w = '0;
        w[POS_RSV_HI]               = rw.hi;
        w[POS_HW_EEE]               = hw_en;
        w[POS_TX_SEEN]              = tx.seen;
        w[POS_TX_LIVE]              = tx.live;
        w[POS_RX_SEEN]              = rx.seen;
        w[POS_RX_LIVE]              = rx.live;
        w[POS_RSV_LO+1:POS_RSV_LO]  = rw.lo;
        w[POS_NP_ABLE]              = 1'b1;
        w[POS_NP_LOC]               = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/lpi_edge_counter.sv
module lpi_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             event_in,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic ev_q;
    logic edge_hit;

    assign edge_hit = event_in & ~ev_q;

    always_ff @(posedge clk) begin
        if (rst) ev_q <= 1'b0;
        else     ev_q <= event_in;
    end

    always_ff @(posedge clk) begin
        if (rst || !enable)
            count <= '0;
        else if (clear)
            count <= CNT_W'(edge_hit);
        else if (edge_hit && count != CNT_MAX)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/lpi_sticky_bit.sv
module lpi_sticky_bit
    import lpi_reg_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable,
    input  logic      lpi_in,
    input  logic      clr_req,
    output lpi_flag_t flag
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) seen_q <= 1'b0;
        else if (lpi_in)    seen_q <= 1'b1;
        else if (clr_req)   seen_q <= 1'b0;
    end

    assign flag.seen = seen_q;
    assign flag.live = lpi_in & enable;
endmodule

// File: rtl/lpi_status_regs.sv
module lpi_status_regs
    import lpi_reg_pkg::*;
#(
    parameter int               ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] WAKE_ERR_ADDR = ADDR_W'('hE2),
    parameter logic [ADDR_W-1:0] LPI_CSR_ADDR  = ADDR_W'('hE4)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              wake_done,
    input  logic              tx_lpi,
    input  logic              rx_lpi,
    input  logic              hw_eee_en,
    input  logic              fiber_mode
);
    localparam int N_DIR = 2;

    reg_sel_e         sel;
    logic             lpi_en;
    logic             rd_cnt;
    logic             wr_csr;
    logic [REG_W-1:0] err_cnt;
    logic [REG_W-1:0] csr_word;
    csr_rw_t          csr_rw;
    lpi_flag_t        flags [N_DIR];
    logic [N_DIR-1:0] lpi_vec;
    logic             tx_seen;
    logic             rx_seen;
    logic             wdata_unused;

    always_comb begin
        if (bus_addr == WAKE_ERR_ADDR)     sel = SEL_CNT;
        else if (bus_addr == LPI_CSR_ADDR) sel = SEL_CSR;
        else                               sel = SEL_NONE;
    end

    assign lpi_en  = ~fiber_mode;
    assign rd_cnt  = bus_rd & (sel == SEL_CNT);
    assign wr_csr  = bus_wr & (sel == SEL_CSR);
    assign lpi_vec = {tx_lpi, rx_lpi};

    lpi_edge_counter #(.CNT_W(REG_W)) u_wake_err (
        .clk      (clk),
        .rst      (rst),
        .enable   (lpi_en),
        .event_in (wake_done),
        .clear    (rd_cnt),
        .count    (err_cnt)
    );

    // index 0 = receive path, index 1 = transmit path
    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
        localparam int SEEN_POS = (g == 0) ? POS_RX_SEEN : POS_TX_SEEN;
        lpi_sticky_bit u_sticky (
            .clk     (clk),
            .rst     (rst),
            .enable  (lpi_en),
            .lpi_in  (lpi_vec[g]),
            .clr_req (wr_csr & bus_wdata[SEEN_POS]),
            .flag    (flags[g])
        );
    end

    assign rx_seen = flags[0].seen;
    assign tx_seen = flags[1].seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            csr_rw <= CSR_RW_RST;
        end else if (wr_csr) begin
            csr_rw.hi <= bus_wdata[POS_RSV_HI];
            csr_rw.lo <= bus_wdata[POS_RSV_LO+1:POS_RSV_LO];
        end
    end

    assign csr_word = pack_csr(csr_rw, hw_eee_en, flags[1], flags[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_CNT: bus_rdata <= err_cnt;
                SEL_CSR: bus_rdata <= csr_word;
                default: bus_rdata <= '0;
            endcase
        end
    end

    assign wdata_unused = ^{bus_wdata[POS_HW_EEE], bus_wdata[POS_TX_LIVE],
                            bus_wdata[POS_RX_LIVE], bus_wdata[7:0]};
endmodule

// File: rtl/lpi_status_regs_chk.sv
module lpi_status_regs_chk #(
    parameter int               ADDR_W        = 8,
    parameter int               W             = 16,
    parameter logic [ADDR_W-1:0] WAKE_ERR_ADDR = ADDR_W'('hE2),
    parameter logic [ADDR_W-1:0] LPI_CSR_ADDR  = ADDR_W'('hE4)
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      bus_rdata,
    input logic              wake_done,
    input logic              tx_lpi,
    input logic              rx_lpi,
    input logic              fiber_mode,
    input logic [W-1:0]      err_cnt,
    input logic              tx_seen,
    input logic              rx_seen
);
    localparam logic [W-1:0] ALL_ONES = '1;

    logic cnt_rd;
    logic csr_wr;
    logic unmapped_rd;
    assign cnt_rd      = bus_rd && bus_addr == WAKE_ERR_ADDR;
    assign csr_wr      = bus_wr && bus_addr == LPI_CSR_ADDR;
    assign unmapped_rd = bus_rd && bus_addr != WAKE_ERR_ADDR && bus_addr != LPI_CSR_ADDR;

    assert_no_count_when_low_R2: assert property (@(posedge clk) disable iff (rst)
        (!fiber_mode && !cnt_rd && !wake_done) |=> err_cnt == $past(err_cnt));

    assert_holds_at_max_R3: assert property (@(posedge clk) disable iff (rst)
        (!fiber_mode && !cnt_rd && err_cnt == ALL_ONES) |=> err_cnt == ALL_ONES);

    assert_read_then_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (cnt_rd && !fiber_mode) |=> (bus_rdata == $past(err_cnt) && err_cnt <= 1));

    assert_tx_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_seen && !fiber_mode && !(csr_wr && bus_wdata[13])) |=> tx_seen);

    assert_rx_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_lpi && !fiber_mode) |=> rx_seen);

    assert_event_beats_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_lpi && !fiber_mode && csr_wr && bus_wdata[13]) |=> tx_seen);

    assert_fiber_zero_R11: assert property (@(posedge clk) disable iff (rst)
        fiber_mode |=> (err_cnt == '0 && !tx_seen && !rx_seen));

    assert_unmapped_zero_R12: assert property (@(posedge clk) disable iff (rst)
        unmapped_rd |=> bus_rdata == '0);
endmodule

bind lpi_status_regs lpi_status_regs_chk #(
    .ADDR_W        (ADDR_W),
    .W             (lpi_reg_pkg::REG_W),
    .WAKE_ERR_ADDR (WAKE_ERR_ADDR),
    .LPI_CSR_ADDR  (LPI_CSR_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .wake_done  (wake_done),
    .tx_lpi     (tx_lpi),
    .rx_lpi     (rx_lpi),
    .fiber_mode (fiber_mode),
    .err_cnt    (err_cnt),
    .tx_seen    (tx_seen),
    .rx_seen    (rx_seen)
);

// File: tb/tb_lpi_status_regs.sv
`timescale 1ns/1ps
module tb_lpi_status_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = 16'h0000;
    logic [15:0] bus_rdata;
    logic        wake_done = 1'b0;
    logic        tx_lpi = 1'b0;
    logic        rx_lpi = 1'b0;
    logic        hw_eee_en = 1'b0;
    logic        fiber_mode = 1'b0;

    always #10 clk = ~clk;

    lpi_status_regs dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wake_done(wake_done), .tx_lpi(tx_lpi), .rx_lpi(rx_lpi),
        .hw_eee_en(hw_eee_en), .fiber_mode(fiber_mode)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string cur_req  = "R1";

    // Behavioural reference model
    int          m_cnt;
    bit          m_wprev, m_txs, m_rxs, m_b15;
    bit [1:0]    m_b98;
    logic [15:0] m_rdata;

    function automatic logic [15:0] model_csr();
        logic [15:0] v = 16'h0060;
        v[15]  = m_b15;
        v[14]  = hw_eee_en;
        v[13]  = m_txs;
        v[12]  = tx_lpi & ~fiber_mode;
        v[11]  = m_rxs;
        v[10]  = rx_lpi & ~fiber_mode;
        v[9:8] = m_b98;
        return v;
    endfunction

    always @(posedge clk) begin
        bit edge_seen;
        if (rst) begin
            m_cnt = 0; m_wprev = 0; m_txs = 0; m_rxs = 0;
            m_b15 = 1; m_b98 = 2'b00; m_rdata = 16'h0000;
        end else begin
            edge_seen = wake_done && !m_wprev;
            m_wprev   = wake_done;
            if (bus_rd) begin
                if (bus_addr == 8'hE2)      m_rdata = 16'(m_cnt);
                else if (bus_addr == 8'hE4) m_rdata = model_csr();
                else                        m_rdata = 16'h0000;
            end
            if (fiber_mode)                           m_cnt = 0;
            else if (bus_rd && bus_addr == 8'hE2)     m_cnt = edge_seen ? 1 : 0;
            else if (edge_seen && m_cnt < 65535)      m_cnt = m_cnt + 1;
            if (fiber_mode)                                         m_txs = 0;
            else if (tx_lpi)                                        m_txs = 1;
            else if (bus_wr && bus_addr == 8'hE4 && bus_wdata[13])  m_txs = 0;
            if (fiber_mode)                                         m_rxs = 0;
            else if (rx_lpi)                                        m_rxs = 1;
            else if (bus_wr && bus_addr == 8'hE4 && bus_wdata[11])  m_rxs = 0;
            if (bus_wr && bus_addr == 8'hE4) begin
                m_b15 = bus_wdata[15];
                m_b98 = bus_wdata[9:8];
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            n_checks++;
            if (bus_rdata !== m_rdata) begin
                n_fail++;
                $display("FAIL %s model compare: actual %h expected %h", cur_req, bus_rdata, m_rdata);
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
            finish_run();
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_expect(logic [7:0] a, logic [15:0] exp, string req);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s read %h: actual %h expected %h", req, a, bus_rdata, exp);
        end
    endtask

    task automatic write_reg(logic [7:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wake_pulse();
        wake_done = 1'b1; @(negedge clk);
        wake_done = 1'b0; @(negedge clk);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);

        cur_req = "R1";
        read_expect(8'hE2, 16'h0000, "R1");
        read_expect(8'hE4, 16'h8060, "R1");

        cur_req = "R2";
        wake_done = 1'b1; cyc(5); wake_done = 1'b0; cyc(1);
        wake_pulse(); wake_pulse();
        read_expect(8'hE2, 16'h0003, "R2");
        cur_req = "R4";
        read_expect(8'hE2, 16'h0000, "R4");

        cur_req = "R5";
        wake_pulse(); wake_pulse();
        wake_done = 1'b1;
        read_expect(8'hE2, 16'h0002, "R5");
        wake_done = 1'b0;
        read_expect(8'hE2, 16'h0001, "R5");

        cur_req = "R6";
        tx_lpi = 1'b1; cyc(1); tx_lpi = 1'b0; cyc(1);
        read_expect(8'hE4, 16'hA060, "R6");
        write_reg(8'hE4, 16'h8000);
        read_expect(8'hE4, 16'hA060, "R6");
        write_reg(8'hE4, 16'hA000);
        read_expect(8'hE4, 16'h8060, "R6");

        cur_req = "R7";
        rx_lpi = 1'b1; cyc(1); rx_lpi = 1'b0; cyc(1);
        read_expect(8'hE4, 16'h8860, "R7");
        write_reg(8'hE4, 16'h8800);
        read_expect(8'hE4, 16'h8060, "R7");

        cur_req = "R9";
        tx_lpi = 1'b1; rx_lpi = 1'b1; cyc(1);
        read_expect(8'hE4, 16'hBC60, "R9");
        tx_lpi = 1'b0; rx_lpi = 1'b0;
        read_expect(8'hE4, 16'hA860, "R9");
        write_reg(8'hE4, 16'hA800);

        cur_req = "R8";
        tx_lpi = 1'b1;
        write_reg(8'hE4, 16'hA000);
        tx_lpi = 1'b0;
        read_expect(8'hE4, 16'hA060, "R8");
        write_reg(8'hE4, 16'hA000);
        read_expect(8'hE4, 16'h8060, "R8");

        cur_req = "R10";
        write_reg(8'hE4, 16'h0000);
        read_expect(8'hE4, 16'h0060, "R10");
        hw_eee_en = 1'b1;
        write_reg(8'hE4, 16'hFFFF);
        read_expect(8'hE4, 16'hC360, "R10");
        hw_eee_en = 1'b0;

        cur_req = "R11";
        fiber_mode = 1'b1; tx_lpi = 1'b1; rx_lpi = 1'b1;
        wake_pulse(); wake_pulse(); wake_pulse();
        read_expect(8'hE2, 16'h0000, "R11");
        read_expect(8'hE4, 16'h8360, "R11");
        tx_lpi = 1'b0; rx_lpi = 1'b0; cyc(1);
        fiber_mode = 1'b0; cyc(1);
        read_expect(8'hE4, 16'h8360, "R11");

        cur_req = "R12";
        read_expect(8'h00, 16'h0000, "R12");
        read_expect(8'hE3, 16'h0000, "R12");

        cur_req = "R3";
        for (int i = 0; i < 65536; i++) wake_pulse();
        read_expect(8'hE2, 16'hFFFF, "R3");
        read_expect(8'hE2, 16'h0000, "R3");

        cyc(2);
        finish_run();
    end
endmodule